// File: doc/BRIEF.md
# Eight-Register GPIO Bank with Masked Atomic Writes

The block groups several byte-wide general-purpose I/O ports behind one 32-bit register window. Every port has eight registers: a per-pin function enable, an output-driver enable, an output value, the synchronised input value, a sticky interrupt status, an interrupt enable, an interrupt polarity, and a write-one-to-clear register. The register address selects one register group and one port within that group. Pad outputs and pad output enables come straight from the port registers. All ports share one interrupt line.

A second copy of the window, offset by 0x800, takes a mask and a value in a single write. Only the pins named in the mask change. Software can therefore flip individual pins of a port shared by several drivers without a read-modify-write sequence.

Pad inputs pass through a two-stage synchroniser before they are read back or compared for interrupts. A status bit sets while its pin is enabled and the synchronised input sits at the level chosen by the polarity bit. The bit stays set until software clears it. The bank interrupt is high whenever any status bit is set together with its enable bit.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register of every port reads 0, and `pad_out`, `pad_oe` and `irq` are 0.
- R2: `bus_addr[6:4]` selects the group: 0 enable, 1 output enable, 2 output value, 3 input value, 4 status, 5 interrupt enable, 6 polarity, 7 clear. `bus_addr[3:2]` selects the port. Port p owns pad bits [8p+7:8p]. Register data sits in bits 7:0, and read bits 31:8 are 0.
- R3: A plain write (`bus_addr[11]`=0) to a writable group replaces all 8 bits of that port's register. The next read returns the written value.
- R4: A write with `bus_addr[11]`=1 is masked. Bits 15:8 choose which bits change, and bits 7:0 give their new values. Bits outside the mask keep their value.
- R5: A masked write with mask bits set and value bits cleared clears exactly those bits and leaves the others set.
- R6: `pad_out` shows each port's output value register. `pad_oe` is high only where both the output enable bit and the function enable bit are set.
- R7: The input value register shows `pad_in` two clock edges after the pad changes. It shows the old value after one edge.
- R8: A status bit sets on the edge after its synchronised input equals its polarity bit (1 means high, 0 means low) while its enable bit is set. The bit stays set after the condition goes away.
- R9: Writing 1 to a bit of the clear group clears that status bit. A masked clear clears the bits where both mask and value are 1. If the trigger condition is still present, the bit sets again.
- R10: `irq` is 1 exactly when some port has a status bit that is set together with its interrupt enable bit.
- R11: Writes to the input value and status groups change nothing. The clear group always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address inside the window; bit 11 selects the masked alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad inputs, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined bank interrupt |

## Verification
The bench builds the bank with its default parameters: four ports of eight pins each. This fills the whole 32-bit pad vectors and uses both port-select address bits, so the top port and the highest group offset are exercised. With eight-pin ports, the mask field fills bits 15:8 of the write data. The masked alias can then be tested with patterns that leave neighbouring pins set, clear them, or toggle them. The bench also covers polarity in both directions, clearing status while the trigger condition is still present, and interrupt masking across ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Register group order inside the window (address bits 6:4).
    typedef enum logic [2:0] {
        GRP_EN   = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_STAT = 3'd4,
        GRP_IE   = 3'd5,
        GRP_LEV  = 3'd6,
        GRP_CLR  = 3'd7
    } grp_e;

    localparam int ALIAS_BIT = 11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  grp_e         wr_grp,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] en_q,
    output logic [W-1:0] oe_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] ie_q,
    output logic [W-1:0] lev_q,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] hit;
    logic [W-1:0] clr;

    function automatic logic [W-1:0] merge(input logic [W-1:0] cur,
                                           input logic [W-1:0] m,
                                           input logic [W-1:0] v);
        return (cur & ~m) | (v & m);
    endfunction

    always_comb begin
        hit = en_q & ~(pin_s ^ lev_q);
        clr = (wr_en && wr_grp == GRP_CLR) ? (wr_mask & wr_val) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            oe_q   <= '0;
            out_q  <= '0;
            ie_q   <= '0;
            lev_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_grp)
                    GRP_EN:  en_q  <= merge(en_q,  wr_mask, wr_val);
                    GRP_OE:  oe_q  <= merge(oe_q,  wr_mask, wr_val);
                    GRP_OUT: out_q <= merge(out_q, wr_mask, wr_val);
                    GRP_IE:  ie_q  <= merge(ie_q,  wr_mask, wr_val);
                    GRP_LEV: lev_q <= merge(lev_q, wr_mask, wr_val);
                    default: ;
                endcase
            end
            // set has priority over clear
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

    // R8: a matching pin sets its status bit on the next edge
    p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));

    // R8: status is sticky without clear or new match
    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_grp == GRP_CLR) && hit == '0) |=> $stable(stat_q));

    // R9: cleared bits with no match go low
    p_stat_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0 && (clr & hit) == '0) |=> ((stat_q & $past(clr)) == '0));

    // R4: bits outside the mask keep their value
    p_out_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp == GRP_OUT) |=>
            ((out_q & ~$past(wr_mask)) == ($past(out_q) & ~$past(wr_mask))));

    // R11: no write to the output group leaves it unchanged
    p_out_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_grp == GRP_OUT) |=> $stable(out_q));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pad_in,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe,
    output logic        irq
);
    localparam int PINS = NUM_PORTS * PORT_W;

    logic [PINS-1:0]   pin_s;
    logic              addr_ok;
    logic              is_alias;
    grp_e              grp;
    logic [1:0]        psel;
    logic [PORT_W-1:0] wmask;
    logic [PORT_W-1:0] wval;
    logic [NUM_PORTS-1:0] port_wr;

    logic [PORT_W-1:0] en_a   [NUM_PORTS];
    logic [PORT_W-1:0] oe_a   [NUM_PORTS];
    logic [PORT_W-1:0] out_a  [NUM_PORTS];
    logic [PORT_W-1:0] ie_a   [NUM_PORTS];
    logic [PORT_W-1:0] lev_a  [NUM_PORTS];
    logic [PORT_W-1:0] stat_a [NUM_PORTS];

    gpio_sync #(.W(PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in[PINS-1:0]),
        .q     (pin_s)
    );

    always_comb begin
        is_alias = bus_addr[ALIAS_BIT];
        addr_ok  = (bus_addr[10:7] == 4'd0) && (bus_addr[1:0] == 2'd0);
        grp      = grp_e'(bus_addr[6:4]);
        psel     = bus_addr[3:2];
        wval     = bus_wdata[PORT_W-1:0];
        wmask    = is_alias ? bus_wdata[2*PORT_W-1:PORT_W] : '1;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign port_wr[p] = bus_wr && addr_ok && (int'(psel) == p);

            gpio_port #(.W(PORT_W)) i_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (port_wr[p]),
                .wr_grp  (grp),
                .wr_mask (wmask),
                .wr_val  (wval),
                .pin_s   (pin_s[p*PORT_W +: PORT_W]),
                .en_q    (en_a[p]),
                .oe_q    (oe_a[p]),
                .out_q   (out_a[p]),
                .ie_q    (ie_a[p]),
                .lev_q   (lev_a[p]),
                .stat_q  (stat_a[p])
            );

            assign pad_out[p*PORT_W +: PORT_W] = out_a[p];
            assign pad_oe[p*PORT_W +: PORT_W]  = oe_a[p] & en_a[p];
        end
        if (PINS < 32) begin : g_pad_fill
            assign pad_out[31:PINS] = '0;
            assign pad_oe[31:PINS]  = '0;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_ok && int'(psel) == p) begin
                unique case (grp)
                    GRP_EN:   bus_rdata[PORT_W-1:0] = en_a[p];
                    GRP_OE:   bus_rdata[PORT_W-1:0] = oe_a[p];
                    GRP_OUT:  bus_rdata[PORT_W-1:0] = out_a[p];
                    GRP_IN:   bus_rdata[PORT_W-1:0] = pin_s[p*PORT_W +: PORT_W];
                    GRP_STAT: bus_rdata[PORT_W-1:0] = stat_a[p];
                    GRP_IE:   bus_rdata[PORT_W-1:0] = ie_a[p];
                    GRP_LEV:  bus_rdata[PORT_W-1:0] = lev_a[p];
                    GRP_CLR:  bus_rdata[PORT_W-1:0] = '0;
                endcase
            end
        end
    end

    always_comb begin
        irq = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            irq = irq | (|(stat_a[p] & ie_a[p]));
        end
    end

    // R2: a write reaches at most one port
    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    function automatic logic [11:0] ad(input int g, input int p, input bit alias_w);
        return 12'(g*16 + p*4 + (alias_w ? 12'h800 : 12'h000));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset_r1();
        logic [31:0] d;
        for (int g = 0; g < 8; g++) begin
            for (int p = 0; p < 4; p++) begin
                rd(ad(g, p, 0), d);
                chk("R1 reg", d, 32'h0);
            end
        end
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map_r2_r3();
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            wr(ad(2, p, 0), 32'hFFFF_FF00 | 32'(8'h11 * (p + 1)));
        end
        for (int p = 0; p < 4; p++) begin
            rd(ad(2, p, 0), d);
            chk("R2 R3 out readback", d, 32'(8'h11 * (p + 1)));
        end
        chk("R2 pad_out slices", pad_out, 32'h4433_2211);
        wr(ad(6, 3, 0), 32'h0000_00A5);
        rd(ad(6, 3, 0), d);
        chk("R3 polarity port3", d, 32'hA5);
        rd(ad(6, 2, 0), d);
        chk("R2 polarity port2 untouched", d, 32'h0);
        wr(ad(6, 3, 0), 32'h0);
    endtask

    task automatic t_mask_r4_r5();
        logic [31:0] d;
        wr(ad(2, 1, 0), 32'h0000_00F0);
        wr(ad(2, 1, 1), 32'h0000_0F05);
        rd(ad(2, 1, 0), d);
        chk("R4 masked set", d, 32'hF5);
        wr(ad(2, 1, 1), 32'h0000_3000);
        rd(ad(2, 1, 0), d);
        chk("R5 masked clear", d, 32'hC5);
        wr(ad(2, 1, 1), 32'h0000_00FF);
        rd(ad(2, 1, 0), d);
        chk("R4 empty mask no change", d, 32'hC5);
    endtask

    task automatic t_oe_r6();
        wr(ad(1, 0, 0), 32'hFF);
        chk("R6 oe without enable", pad_oe, 32'h0);
        wr(ad(0, 0, 0), 32'h3C);
        chk("R6 oe gated by enable", pad_oe, 32'h0000_003C);
        wr(ad(0, 0, 0), 32'h0);
        wr(ad(1, 0, 0), 32'h0);
    endtask

    task automatic t_sync_r7();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = ad(3, 2, 0);
        pad_in   = 32'h005A_0000;
        @(posedge clk);
        #1 chk("R7 one edge old", bus_rdata, 32'h0);
        @(posedge clk);
        #1 chk("R7 two edges new", bus_rdata, 32'h5A);
        pad_in = 32'h0;
        repeat (3) @(posedge clk);
        rd(ad(3, 2, 0), d);
        chk("R7 back to zero", d, 32'h0);
    endtask

    task automatic t_status_r8_r9_r10();
        logic [31:0] d;
        wr(ad(6, 1, 0), 32'h0F);
        wr(ad(0, 1, 0), 32'h0F);
        @(negedge clk);
        pad_in = 32'h0000_0500;
        repeat (4) @(posedge clk);
        rd(ad(4, 1, 0), d);
        chk("R8 high level match", d, 32'h05);
        wr(ad(6, 1, 1), 32'h0000_0200);
        repeat (2) @(posedge clk);
        rd(ad(4, 1, 0), d);
        chk("R8 low level match", d, 32'h07);
        wr(ad(6, 1, 0), 32'h0F);
        @(negedge clk);
        pad_in = 32'h0;
        repeat (4) @(posedge clk);
        rd(ad(4, 1, 0), d);
        chk("R8 sticky", d, 32'h07);
        wr(ad(7, 1, 0), 32'h01);
        rd(ad(4, 1, 0), d);
        chk("R9 plain clear", d, 32'h06);
        wr(ad(7, 1, 1), 32'h0000_0604);
        rd(ad(4, 1, 0), d);
        chk("R9 masked clear", d, 32'h02);
        chk("R10 no enable no irq", {31'b0, irq}, 32'h0);
        wr(ad(5, 1, 0), 32'h02);
        chk("R10 irq on", {31'b0, irq}, 32'h1);
        wr(ad(5, 1, 0), 32'h01);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        @(negedge clk);
        pad_in = 32'h0000_0100;
        repeat (4) @(posedge clk);
        wr(ad(7, 1, 0), 32'h01);
        rd(ad(4, 1, 0), d);
        chk("R9 condition present resets", d, 32'h03);
        chk("R10 irq from port1", {31'b0, irq}, 32'h1);
        @(negedge clk);
        pad_in = 32'h0;
        repeat (3) @(posedge clk);
        wr(ad(7, 1, 0), 32'hFF);
        chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ro_r11();
        logic [31:0] d;
        wr(ad(4, 1, 0), 32'hFF);
        rd(ad(4, 1, 0), d);
        chk("R11 status not writable", d, 32'h0);
        wr(ad(3, 0, 0), 32'hFF);
        rd(ad(3, 0, 0), d);
        chk("R11 input not writable", d, 32'h0);
        rd(ad(7, 1, 0), d);
        chk("R11 clear reads zero", d, 32'h0);
        chk("R11 pad_out unchanged", pad_out, 32'h4433_C511);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_r1();
        t_map_r2_r3();
        t_mask_r4_r5();
        t_oe_r6();
        t_sync_r7();
        t_status_r8_r9_r10();
        t_ro_r11();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule